// File: doc/BRIEF.md
# Frame-Indexed Operand Matching Stage

This block sits in a dataflow pipeline between token delivery and the execution unit. A token arrives with a context, a target instruction, an input port and a data value. The context is the base address of the activation frame that belongs to one invocation. A small built-in instruction table gives each instruction a frame offset, an input count and an opcode. Adding the offset to the context gives the slot address. That slot holds one stored operand and a presence bit.

A token for a one-input instruction fires at once. A token for a two-input instruction waits in its slot when the presence bit is clear. When the bit is already set, the token takes its waiting partner from the slot, clears the bit and fires. A fire record carries the token's context, the instruction, the opcode, and the two operands in port order. The instruction table is shared by all invocations. Slot storage is private to each frame. Every output is registered, so a fire record appears one clock after the token that completes it.

Top module: `token_match_unit`

## Requirements
- R1: After synchronous active-high reset, `fire_valid` is 0 and every presence bit is clear, so the first token to any two-input instruction is stored and does not fire.
- R2: The instruction table maps instruction id i to frame offset i and opcode i (low OPC_W bits). An instruction with bit 0 of its id equal to 0 takes two inputs. An instruction with bit 0 equal to 1 takes one input.
- R3: The slot address is (context + offset) modulo FRAME_DEPTH. Two tokens whose sums wrap to the same slot share that slot's storage and presence bit.
- R4: A token for a two-input instruction whose slot presence bit is clear is stored. The bit is set, and no fire record follows in the next cycle.
- R5: A token for a two-input instruction whose slot presence bit is set produces a fire record in the next cycle and clears the bit. A third token to that slot is stored again.
- R6: In a fire record for a two-input instruction, `fire_left` is the value that came on port 0 and `fire_right` is the value that came on port 1, whichever arrived first.
- R7: A token for a one-input instruction fires in the next cycle with `fire_left` equal to its value and `fire_right` equal to 0, and it leaves all slots unchanged.
- R8: A fire record carries the context and instruction id of the token that completed it. It also carries that instruction's opcode.
- R9: Tokens to the same slot on consecutive cycles are matched correctly. Each cycle sees the slot state left by the previous cycle.
- R10: Pairs waiting in different frames do not disturb one another when their tokens are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Token present this cycle |
| in_ctx | input | ADDR_W | Frame base (context) of the token |
| in_instr | input | INS_W | Destination instruction id |
| in_port | input | 1 | Destination input port (0 or 1) |
| in_value | input | DATA_W | Token value |
| fire_valid | output | 1 | Fire record present |
| fire_ctx | output | ADDR_W | Context inherited from the completing token |
| fire_instr | output | INS_W | Instruction that fired |
| fire_opcode | output | OPC_W | Opcode from the instruction table |
| fire_left | output | DATA_W | Port 0 operand |
| fire_right | output | DATA_W | Port 1 operand, 0 for one-input instructions |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that the two tokens meeting in a slot carry different ports, as a compiler that assigns distinct ports per instruction would ensure. The stimulus keeps to both. It drives `in_valid` low during reset. For every pair it chooses the second token's port as the opposite of the port already waiting. That choice is tracked by the bench's own slot model, including in the pseudo-random phase.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  typedef enum logic {
    ARITY_ONE = 1'b0,
    ARITY_TWO = 1'b1
  } arity_e;

  // Table rule: offset = id, opcode = id, two inputs when id bit 0 is 0.
  function automatic arity_e arity_of(input int unsigned id);
    return (id % 2 == 0) ? ARITY_TWO : ARITY_ONE;
  endfunction

endpackage

// File: rtl/tmu_itable.sv
module tmu_itable
  import tmu_pkg::*;
#(
  parameter int INS_W = 4,
  parameter int OFF_W = 6,
  parameter int OPC_W = 4
) (
  input  logic [INS_W-1:0] instr,
  output logic [OFF_W-1:0] offset,
  output arity_e           arity,
  output logic [OPC_W-1:0] opcode
);

  localparam int NUM_INSTR = 2 ** INS_W;

  logic [OFF_W-1:0] off_tab [NUM_INSTR];
  arity_e           ar_tab  [NUM_INSTR];
  logic [OPC_W-1:0] opc_tab [NUM_INSTR];

  for (genvar g = 0; g < NUM_INSTR; g++) begin : g_entry
    assign off_tab[g] = OFF_W'(g);
    assign ar_tab[g]  = arity_of(g);
    assign opc_tab[g] = OPC_W'(g);
  end

  assign offset = off_tab[instr];
  assign arity  = ar_tab[instr];
  assign opcode = opc_tab[instr];

endmodule

// File: rtl/tmu_frame_store.sv
module tmu_frame_store #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] value,
  output logic              present,
  output logic [DATA_W-1:0] partner
);

  localparam int DEPTH = 2 ** ADDR_W;

  logic [DEPTH-1:0]  pres_q;
  logic [DATA_W-1:0] val_mem [DEPTH];

  assign present = pres_q[addr];
  assign partner = val_mem[addr];

  // Value storage: write-only clocked process, no reset (RAM-friendly).
  always_ff @(posedge clk) begin
    if (req && !present) val_mem[addr] <= value;
  end

  // Presence bits: flip in the same cycle as the lookup.
  always_ff @(posedge clk) begin
    if (rst) begin
      pres_q <= '0;
    end else if (req) begin
      pres_q[addr] <= !present;
    end
  end

  p_set_after_store_r4: assert property (@(posedge clk) disable iff (rst)
    (req && !present) |=> pres_q[$past(addr)]);

  p_clear_after_match_r5: assert property (@(posedge clk) disable iff (rst)
    (req && present) |=> !pres_q[$past(addr)]);

  p_idle_keeps_bits_r7: assert property (@(posedge clk) disable iff (rst)
    !req |=> $stable(pres_q));

endmodule

// File: rtl/token_match_unit.sv
module token_match_unit
  import tmu_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int INS_W  = 4,
  parameter int OPC_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_ctx,
  input  logic [INS_W-1:0]  in_instr,
  input  logic              in_port,
  input  logic [DATA_W-1:0] in_value,
  output logic              fire_valid,
  output logic [ADDR_W-1:0] fire_ctx,
  output logic [INS_W-1:0]  fire_instr,
  output logic [OPC_W-1:0]  fire_opcode,
  output logic [DATA_W-1:0] fire_left,
  output logic [DATA_W-1:0] fire_right
);

  logic [ADDR_W-1:0] offset;
  arity_e            arity;
  logic [OPC_W-1:0]  opcode;
  logic [ADDR_W-1:0] slot;
  logic              two_in;
  logic              store_req;
  logic              hit;
  logic [DATA_W-1:0] partner;
  logic              fire_d;
  logic [DATA_W-1:0] left_d;
  logic [DATA_W-1:0] right_d;

  tmu_itable #(.INS_W(INS_W), .OFF_W(ADDR_W), .OPC_W(OPC_W)) i_itable (
    .instr  (in_instr),
    .offset (offset),
    .arity  (arity),
    .opcode (opcode)
  );

  assign slot      = ADDR_W'(in_ctx + offset);
  assign two_in    = (arity == ARITY_TWO);
  assign store_req = in_valid && two_in;

  tmu_frame_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_frame (
    .clk     (clk),
    .rst     (rst),
    .req     (store_req),
    .addr    (slot),
    .value   (in_value),
    .present (hit),
    .partner (partner)
  );

  always_comb begin
    fire_d  = in_valid && (!two_in || hit);
    left_d  = in_value;
    right_d = '0;
    if (two_in) begin
      if (in_port) begin
        left_d  = partner;
        right_d = in_value;
      end else begin
        right_d = partner;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_valid <= 1'b0;
    end else begin
      fire_valid <= fire_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fire_d) begin
      fire_ctx    <= in_ctx;
      fire_instr  <= in_instr;
      fire_opcode <= opcode;
      fire_left   <= left_d;
      fire_right  <= right_d;
    end
  end

  p_fire_needs_token_r5: assert property (@(posedge clk) disable iff (rst)
    fire_valid |-> $past(in_valid));

  p_ctx_inherited_r8: assert property (@(posedge clk) disable iff (rst)
    fire_valid |-> (fire_ctx == $past(in_ctx) && fire_instr == $past(in_instr)));

  p_single_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !two_in) |=> (fire_valid && fire_right == '0));

  p_first_is_silent_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && two_in && !hit) |=> !fire_valid);

endmodule

// File: tb/test_token_match_unit.sv
module test_token_match_unit;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int INS_W  = 4;
  localparam int OPC_W  = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 2 ** ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [ADDR_W-1:0] in_ctx = '0;
  logic [INS_W-1:0]  in_instr = '0;
  logic              in_port = 1'b0;
  logic [DATA_W-1:0] in_value = '0;
  logic              fire_valid;
  logic [ADDR_W-1:0] fire_ctx;
  logic [INS_W-1:0]  fire_instr;
  logic [OPC_W-1:0]  fire_opcode;
  logic [DATA_W-1:0] fire_left;
  logic [DATA_W-1:0] fire_right;

  token_match_unit #(.ADDR_W(ADDR_W), .INS_W(INS_W), .OPC_W(OPC_W), .DATA_W(DATA_W))
    i_token_match_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ctx(in_ctx), .in_instr(in_instr),
    .in_port(in_port), .in_value(in_value), .fire_valid(fire_valid), .fire_ctx(fire_ctx),
    .fire_instr(fire_instr), .fire_opcode(fire_opcode), .fire_left(fire_left),
    .fire_right(fire_right)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit                fires;
    logic [ADDR_W-1:0] ctx;
    logic [INS_W-1:0]  ins;
    logic [DATA_W-1:0] left;
    logic [DATA_W-1:0] right;
    string             req;
    int                cyc;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Bench slot model built from R2/R3.
  bit                m_pres [DEPTH];
  logic [DATA_W-1:0] m_val  [DEPTH];
  bit                m_port [DEPTH];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic send(input int c, input int i, input bit p, input int v, input string req);
    exp_t e;
    int s;
    @(negedge clk);
    in_valid = 1'b1;
    in_ctx   = ADDR_W'(c);
    in_instr = INS_W'(i);
    in_port  = p;
    in_value = DATA_W'(v);
    s = (c + i) % DEPTH;
    e.cyc = cyc; e.req = req; e.ctx = ADDR_W'(c); e.ins = INS_W'(i);
    e.left = '0; e.right = '0;
    if (i % 2 == 1) begin
      e.fires = 1'b1; e.left = DATA_W'(v);
    end else if (m_pres[s]) begin
      e.fires = 1'b1;
      if (p) begin e.left = m_val[s]; e.right = DATA_W'(v); end
      else   begin e.left = DATA_W'(v); e.right = m_val[s]; end
      m_pres[s] = 1'b0;
    end else begin
      e.fires = 1'b0;
      m_pres[s] = 1'b1; m_val[s] = DATA_W'(v); m_port[s] = p;
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare each token's outcome one cycle after it was accepted.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].cyc == cyc - 1) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (fire_valid !== e.fires) begin
          fails++;
          $display("FAIL %s: fire_valid actual %0b expected %0b", e.req, fire_valid, e.fires);
        end else if (e.fires && (fire_ctx !== e.ctx || fire_instr !== e.ins ||
                     fire_opcode !== OPC_W'(e.ins) || fire_left !== e.left ||
                     fire_right !== e.right)) begin
          fails++;
          $display("FAIL %s: actual ctx=%0d ins=%0d opc=%0d L=%0h R=%0h expected ctx=%0d ins=%0d opc=%0d L=%0h R=%0h",
                   e.req, fire_ctx, fire_instr, fire_opcode, fire_left, fire_right,
                   e.ctx, e.ins, OPC_W'(e.ins), e.left, e.right);
        end
      end else if (fire_valid) begin
        checks++; fails++;
        $display("FAIL R4: unexpected fire actual 1 expected 0 (ctx=%0d ins=%0d)",
                 fire_ctx, fire_instr);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) m_pres[k] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (fire_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: fire_valid after reset actual %0b expected 0", fire_valid);
    end

    // R1 R4: first token after reset is held; R7 single-input fires alone.
    send(5, 2, 1'b0, 16'h0A01, "R1");
    send(3, 1, 1'b1, 16'h1234, "R7");
    // R5 R8: partner arrives and fires with context and opcode.
    send(5, 2, 1'b1, 16'h0B02, "R5");
    idle(2);
    // R6: port 1 first, then port 0.
    send(12, 6, 1'b1, 16'h2222, "R6");
    idle(1);
    send(12, 6, 1'b0, 16'h1111, "R6");
    // R9: four back-to-back tokens to one slot.
    send(20, 8, 1'b0, 16'h0301, "R9");
    send(20, 8, 1'b1, 16'h0302, "R9");
    send(20, 8, 1'b1, 16'h0303, "R9");
    send(20, 8, 1'b0, 16'h0304, "R9");
    // R10: two frames interleaved on the same instruction.
    send(30, 4, 1'b0, 16'h0A0A, "R10");
    send(40, 4, 1'b0, 16'h0B0B, "R10");
    send(40, 4, 1'b1, 16'h0B0C, "R10");
    send(30, 4, 1'b1, 16'h0A0C, "R10");
    // R3: (62+4) wraps to slot 2, shared with (0+2).
    send(62, 4, 1'b0, 16'h6204, "R3");
    send(0, 2, 1'b1, 16'h0002, "R3");
    // R3: (7+2) and (9+0) share slot 9.
    send(7, 2, 1'b1, 16'h0702, "R3");
    send(9, 0, 1'b0, 16'h0900, "R3");
    // R7: single-input token between a pair leaves the slot intact.
    send(50, 10, 1'b0, 16'h5A00, "R7");
    send(50, 11, 1'b0, 16'h5B00, "R7");
    send(50, 10, 1'b1, 16'h5A01, "R7");
    // R2: every table entry, via a wide sweep.
    for (int k = 0; k < 16; k++) send(16, k, 1'b0, 16'h4000 + k, "R2");
    for (int k = 0; k < 16; k += 2) send(16, k, 1'b1, 16'h4100 + k, "R2");
    idle(2);
    // Mixed pseudo-random stream checked against the bench model.
    for (int k = 0; k < 60; k++) begin
      int c, i, s;
      bit p;
      c = (k % 3) * 8;
      i = (k * 5 + k / 4) % 10;
      s = (c + i) % DEPTH;
      p = m_pres[s] ? !m_port[s] : bit'(k % 2);
      send(c, i, p, k * 37 + 1, (i % 2 == 1) ? "R7" : "R9");
    end
    idle(3);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R5: pending expectations actual %0d expected 0", q.size());
    end
    finish_run();
  end

endmodule